// File: doc/BRIEF.md
# Programmable Watchdog Supervisor with Shared Reset Pulse

This block supervises the control core of a motor driver. It drives one active-high reset output that serves two purposes: the power-on reset pulse that follows a chip reset, and the pulse the watchdog issues when software stops responding. Both pulses last the same fixed number of clock cycles. After power-up the watchdog stays dormant. It arms only when the host writes an enable bit together with a 4-bit timeout code through the register interface. That write is modelled here as a single-cycle strobe with its data.

While the watchdog is armed, it counts base ticks from an external prescaler strobe. The timeout is (code+1) ticks. Software must acknowledge inside a window. An acknowledge that comes too soon (fewer than a minimum number of ticks since the last restart) is a fault and fires the reset pulse at once. An acknowledge that comes in time restarts the count. If the count reaches its limit, the pulse fires. Any watchdog pulse also drops the enable, so software must arm the watchdog again. A hard-clear input returns the whole block to its disabled state without producing any pulse.

Top module: `wdog_supervisor`

## Requirements
- R1: While `rst_n` is low, `wd_rst_o` is 1 and `wd_en_o` is 0. After `rst_n` rises, `wd_rst_o` stays 1 for exactly PULSE_CYC clock edges (counting the first edge with `rst_n` high), then it returns to 0.
- R2: While the enable is 0, no sequence of `tick_i` or `ack_i` causes `wd_rst_o` to rise.
- R3: A `cfg_wr_i` strobe accepted while `wd_rst_o` is 1 has no effect: `wd_en_o` stays 0.
- R4: A `cfg_wr_i` with `cfg_en_i`=1 and `cfg_wdt_i`=W sets `wd_en_o` to 1 on the next edge and clears the tick count. Without an acknowledge, the (W+1)-th tick after the write makes `wd_rst_o` 1 on that tick's edge.
- R5: An acknowledge that arrives when at least MIN_TICKS ticks have elapsed since the last restart clears the count. The timeout is then measured again from that acknowledge.
- R6: An acknowledge that arrives when fewer than MIN_TICKS ticks have elapsed while the watchdog is enabled makes `wd_rst_o` 1 on that acknowledge's edge.
- R7: Every pulse on `wd_rst_o` that no hard clear cuts short lasts exactly PULSE_CYC cycles, whether it comes from reset or from the watchdog.
- R8: The edge that starts a watchdog pulse clears `wd_en_o`. No later pulse occurs until the watchdog is enabled again.
- R9: On the edge that samples `hard_clr_i` high, `wd_en_o` and `wd_rst_o` go to 0. They stay 0 while `hard_clr_i` is held. A timeout that falls on the same edge produces no pulse. Releasing the hard clear starts no pulse.
- R10: When a valid acknowledge and the tick that would expire the timeout arrive in the same cycle, the acknowledge wins: there is no pulse, and the count restarts from zero.
- R11: A `cfg_wr_i` with `cfg_en_i`=0 disables the watchdog. After that, ticks and acknowledges have no effect on `wd_rst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| hard_clr_i | input | 1 | Synchronous hard clear, active high |
| tick_i | input | 1 | Base tick strobe from the prescaler |
| ack_i | input | 1 | Watchdog acknowledge strobe |
| cfg_wr_i | input | 1 | Register write strobe for enable and timeout code |
| cfg_en_i | input | 1 | Enable bit written on `cfg_wr_i` |
| cfg_wdt_i | input | WDT_W | Timeout code written on `cfg_wr_i` |
| wd_en_o | output | 1 | Current enable bit (readback) |
| wd_rst_o | output | 1 | Shared power-on / watchdog reset pulse, active high |

## Verification
Two pairs of events can fall on the same edge. The first pair is the tick that completes the timeout and a valid acknowledge. The bench drives both in one cycle once exactly the code's number of ticks have elapsed. It then expects no pulse, followed by a fresh full timeout measured from that edge. The second pair is a hard clear on the very edge where the timeout expires. Here the expected result is a silent output and a cleared enable. A behavioural model of both cases is compared with the outputs on every clock.

// File: rtl/wdog_pkg.sv
// Package: shared types for the watchdog supervisor.
// Assumes: nothing beyond IEEE 1800-2017.
package wdog_pkg;

    // Events the timing window reports in one cycle
    typedef struct packed {
        logic ack_ok;   // acknowledge inside the allowed window
        logic early;    // acknowledge before the minimum time
        logic expire;   // timeout reached without acknowledge
    } win_evt_t;

    // True when the window reports an event that must fire a pulse
    function automatic logic evt_fires(input win_evt_t e);
        return e.early | e.expire;
    endfunction

endpackage

// File: rtl/wdog_window.sv
// Module: wdog_window
// Counts base ticks since the last restart and classifies acknowledges
// against a lower bound (MIN_TICKS) and the programmed limit (limit_i+1).
// Assumes: tick_i and ack_i are single-cycle strobes synchronous to clk;
// clear_i restarts the count; run_i low holds the count at zero.
module wdog_window
    import wdog_pkg::*;
#(
    parameter int unsigned WDT_W     = 4,
    parameter int unsigned MIN_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             ack_i,
    input  logic [WDT_W-1:0] limit_i,
    output win_evt_t         evt_o
);

    localparam int unsigned EL_W = WDT_W + 1;

    logic [EL_W-1:0] elapsed_q;
    logic            ack_ok;
    logic            early;
    logic            at_limit;

    // Low-bound check; a zero bound makes every acknowledge valid
    generate
        if (MIN_TICKS == 0) begin : g_no_min
            assign early  = 1'b0;
            assign ack_ok = run_i & ack_i;
        end else begin : g_min
            logic below_min;
            assign below_min = (elapsed_q < EL_W'(MIN_TICKS));
            assign early     = run_i & ack_i & below_min;
            assign ack_ok    = run_i & ack_i & ~below_min;
        end
    endgenerate

    assign at_limit = (elapsed_q == {1'b0, limit_i});

    // Classify the cycle: a valid acknowledge beats an expiring tick
    always_comb begin
        evt_o.ack_ok = ack_ok;
        evt_o.early  = early;
        evt_o.expire = run_i & tick_i & at_limit & ~ack_i;
    end

    // Elapsed tick counter with restart on clear, disable or acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed_q <= '0;
        end else if (clear_i || !run_i || ack_ok || early) begin
            elapsed_q <= '0;
        end else if (tick_i && !at_limit) begin
            elapsed_q <= elapsed_q + EL_W'(1);
        end
    end

endmodule

// File: rtl/wdog_pulse.sv
// Module: wdog_pulse
// Generates the fixed-width reset pulse. The power-on reset loads the
// pulse, fire_i reloads it, and clear_i aborts it. The output is a flop.
// Assumes: PULSE_CYC >= 1.
module wdog_pulse #(
    parameter int unsigned PULSE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic fire_i,
    output logic pulse_o
);

    localparam int unsigned CNT_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYC - 1);

    logic [CNT_W-1:0] left_q;
    logic             active_q;

    // Pulse state: start on reset or fire, count down, abort on clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b1;
            left_q   <= LOAD;
        end else if (clear_i) begin
            active_q <= 1'b0;
            left_q   <= '0;
        end else if (fire_i) begin
            active_q <= 1'b1;
            left_q   <= LOAD;
        end else if (active_q) begin
            if (left_q == '0) begin
                active_q <= 1'b0;
            end else begin
                left_q <= left_q - CNT_W'(1);
            end
        end
    end

    assign pulse_o = active_q;

endmodule

// File: rtl/wdog_cfg.sv
// Module: wdog_cfg
// Holds the enable bit and the timeout code. A fire or a hard clear wins
// over a write, and writes are refused while the reset pulse is active.
// Assumes: wr_i is a single-cycle strobe.
module wdog_cfg #(
    parameter int unsigned WDT_W   = 4,
    parameter int unsigned RST_WDT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             fire_i,
    input  logic             busy_i,
    input  logic             wr_i,
    input  logic             wr_en_i,
    input  logic [WDT_W-1:0] wr_wdt_i,
    output logic             en_o,
    output logic [WDT_W-1:0] wdt_o,
    output logic             accepted_o
);

    logic             en_q;
    logic [WDT_W-1:0] wdt_q;

    assign accepted_o = wr_i & ~busy_i & ~fire_i & ~clear_i;

    // Register update with priority reset > clear > fire > write
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            en_q  <= 1'b0;
            wdt_q <= WDT_W'(RST_WDT);
        end else if (fire_i) begin
            en_q  <= 1'b0;
        end else if (accepted_o) begin
            en_q  <= wr_en_i;
            wdt_q <= wr_wdt_i;
        end
    end

    assign en_o  = en_q;
    assign wdt_o = wdt_q;

endmodule

// File: rtl/wdog_supervisor.sv
// Module: wdog_supervisor (top)
// Watchdog supervisor with one shared power-on / watchdog reset output.
// It ties together the configuration register, the timing window and
// the pulse generator.
// Assumes: all inputs are synchronous to clk; tick_i comes from an
// external prescaler; MIN_TICKS <= timeout code for a usable window.
module wdog_supervisor
    import wdog_pkg::*;
#(
    parameter int unsigned WDT_W     = 4,
    parameter int unsigned PULSE_CYC = 8,
    parameter int unsigned MIN_TICKS = 2,
    parameter int unsigned RST_WDT   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hard_clr_i,
    input  logic             tick_i,
    input  logic             ack_i,
    input  logic             cfg_wr_i,
    input  logic             cfg_en_i,
    input  logic [WDT_W-1:0] cfg_wdt_i,
    output logic             wd_en_o,
    output logic             wd_rst_o
);

    logic             en_w;
    logic [WDT_W-1:0] wdt_w;
    logic             wr_acc_w;
    logic             pulse_w;
    logic             run_w;
    logic             fire_w;
    win_evt_t         evt_w;

    assign run_w  = en_w & ~pulse_w;
    assign fire_w = evt_fires(evt_w) & ~hard_clr_i;

    wdog_cfg #(
        .WDT_W   (WDT_W),
        .RST_WDT (RST_WDT)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (hard_clr_i),
        .fire_i     (fire_w),
        .busy_i     (pulse_w),
        .wr_i       (cfg_wr_i),
        .wr_en_i    (cfg_en_i),
        .wr_wdt_i   (cfg_wdt_i),
        .en_o       (en_w),
        .wdt_o      (wdt_w),
        .accepted_o (wr_acc_w)
    );

    wdog_window #(
        .WDT_W     (WDT_W),
        .MIN_TICKS (MIN_TICKS)
    ) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (hard_clr_i | wr_acc_w),
        .run_i   (run_w),
        .tick_i  (tick_i),
        .ack_i   (ack_i),
        .limit_i (wdt_w),
        .evt_o   (evt_w)
    );

    wdog_pulse #(
        .PULSE_CYC (PULSE_CYC)
    ) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (hard_clr_i),
        .fire_i  (fire_w),
        .pulse_o (pulse_w)
    );

    assign wd_en_o  = en_w;
    assign wd_rst_o = pulse_w;

endmodule

// File: rtl/wdog_supervisor_chk.sv
// Module: wdog_supervisor_chk
// Property checker attached to every wdog_supervisor instance.
// Assumes: it observes only the ports of the top module.
module wdog_supervisor_chk #(
    parameter int unsigned WDT_W     = 4,
    parameter int unsigned PULSE_CYC = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hard_clr_i,
    input logic             tick_i,
    input logic             ack_i,
    input logic             cfg_wr_i,
    input logic             cfg_en_i,
    input logic [WDT_W-1:0] cfg_wdt_i,
    input logic             wd_en_o,
    input logic             wd_rst_o
);

    int unsigned high_run_q;

    // Length of the current run of high output cycles since reset
    always_ff @(posedge clk) begin
        if (!rst_n) high_run_q <= 0;
        else if (wd_rst_o) high_run_q <= high_run_q + 1;
        else high_run_q <= 0;
    end

    // Leaving reset finds the pulse active and the enable clear (R1)
    assert_por_start_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (wd_rst_o && !wd_en_o));

    // A pulse that no clear cuts short has the full width (R7)
    assert_pulse_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wd_rst_o) && !$past(hard_clr_i)) |-> (high_run_q == PULSE_CYC));

    // No pulse outlasts its width (R7)
    always_ff @(posedge clk) begin
        if (rst_n) assert_pulse_bound_R7: assert (high_run_q <= PULSE_CYC);
    end

    // A watchdog pulse starts with the enable already cleared (R8)
    assert_fire_disables_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_rst_o) |-> !wd_en_o);

    // A hard clear silences the output and clears the enable (R9)
    assert_hard_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hard_clr_i |=> (!wd_rst_o && !wd_en_o));

    // A write during the pulse does not enable the watchdog (R3)
    assert_write_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n || hard_clr_i)
        (wd_rst_o && cfg_wr_i) |=> !wd_en_o);

    // A disabled, quiet watchdog stays quiet (R11)
    assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_en_o && !wd_rst_o) |=> !wd_rst_o);

endmodule

bind wdog_supervisor wdog_supervisor_chk #(
    .WDT_W     (WDT_W),
    .PULSE_CYC (PULSE_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hard_clr_i (hard_clr_i),
    .tick_i     (tick_i),
    .ack_i      (ack_i),
    .cfg_wr_i   (cfg_wr_i),
    .cfg_en_i   (cfg_en_i),
    .cfg_wdt_i  (cfg_wdt_i),
    .wd_en_o    (wd_en_o),
    .wd_rst_o   (wd_rst_o)
);

// File: tb/wdog_supervisor_test.sv
// Bench for wdog_supervisor: a behavioural reference model compared on
// every clock, plus directed checks at the cycles the requirements name.
module wdog_supervisor_test;

    localparam int WDT_W     = 4;
    localparam int PULSE_CYC = 8;
    localparam int MIN_TICKS = 2;
    localparam int RST_WDT   = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             hard_clr_i = 1'b0;
    logic             tick_i = 1'b0;
    logic             ack_i = 1'b0;
    logic             cfg_wr_i = 1'b0;
    logic             cfg_en_i = 1'b0;
    logic [WDT_W-1:0] cfg_wdt_i = '0;
    logic             wd_en_o;
    logic             wd_rst_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;
    bit cmp_on  = 1'b0;

    // Reference model state
    bit m_out;
    bit m_en;
    int m_left;
    int m_wdt;
    int m_ticks;

    always #4 clk = ~clk;

    wdog_supervisor #(
        .WDT_W     (WDT_W),
        .PULSE_CYC (PULSE_CYC),
        .MIN_TICKS (MIN_TICKS),
        .RST_WDT   (RST_WDT)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .hard_clr_i (hard_clr_i),
        .tick_i     (tick_i),
        .ack_i      (ack_i),
        .cfg_wr_i   (cfg_wr_i),
        .cfg_en_i   (cfg_en_i),
        .cfg_wdt_i  (cfg_wdt_i),
        .wd_en_o    (wd_en_o),
        .wd_rst_o   (wd_rst_o)
    );

    // Behavioural model of the requirements, advanced on each edge
    always @(posedge clk) begin
        bit armed, good, soon, timeout, fire, took;
        if (!rst_n) begin
            m_out = 1; m_left = PULSE_CYC; m_en = 0; m_wdt = RST_WDT; m_ticks = 0;
        end else if (hard_clr_i) begin
            m_out = 0; m_left = 0; m_en = 0; m_wdt = RST_WDT; m_ticks = 0;
        end else begin
            armed   = m_en && !m_out;
            good    = armed && ack_i && (m_ticks >= MIN_TICKS);
            soon    = armed && ack_i && (m_ticks < MIN_TICKS);
            timeout = armed && tick_i && !ack_i && (m_ticks == m_wdt);
            fire    = soon || timeout;
            took    = cfg_wr_i && !m_out && !fire;
            if (fire) begin
                m_en = 0;
            end else if (took) begin
                m_en = cfg_en_i; m_wdt = int'(cfg_wdt_i);
            end
            if (!armed || good || fire || took) m_ticks = 0;
            else if (tick_i) m_ticks++;
            // pulse: remaining high cycles counted down
            if (fire) begin
                m_out = 1; m_left = PULSE_CYC;
            end else if (m_out) begin
                m_left--;
                if (m_left == 0) m_out = 0;
            end
        end
    end

    // Per-clock comparison with the model, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            n_tests++;
            if (wd_rst_o !== m_out) begin
                n_fail++;
                $display("FAIL R7 model: wd_rst_o=%0b expected %0b at cycle %0d", wd_rst_o, m_out, cycles);
            end
            n_tests++;
            if (wd_en_o !== m_en) begin
                n_fail++;
                $display("FAIL R8 model: wd_en_o=%0b expected %0b at cycle %0d", wd_en_o, m_en, cycles);
            end
        end
    end

    task automatic chk(input logic got, input logic exp, input string tag);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    // Apply one cycle of inputs; returns at the following falling edge
    task automatic step(input bit t, input bit a, input bit w, input bit e,
                        input int d, input bit h);
        tick_i = t; ack_i = a; cfg_wr_i = w; cfg_en_i = e;
        cfg_wdt_i = WDT_W'(d); hard_clr_i = h;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            step(1, 0, 0, 0, 0, 0);
            if (i != n - 1) step(0, 0, 0, 0, 0, 0);
        end
    endtask

    task automatic arm(input int code);
        step(0, 0, 1, 1, code, 0);
    endtask

    task automatic wait_pulse_end();
        idle(PULSE_CYC + 1);
    endtask

    // Watchdog on the whole run
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run hung, got %0d cycles expected < 20000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int highs;
        @(negedge clk);
        cmp_on = 1'b1;
        rst_n = 1'b0;
        idle(3);
        chk(wd_rst_o, 1'b1, "R1 out high in reset");
        chk(wd_en_o, 1'b0, "R1 enable low in reset");
        rst_n = 1'b1;
        // R1: count high samples after release; R3: write during pulse
        highs = 0;
        for (int i = 0; i < PULSE_CYC + 3; i++) begin
            if (i == 1) step(0, 0, 1, 1, 3, 0);
            else idle(1);
            if (wd_rst_o) highs++;
            if (i == 1) chk(wd_en_o, 1'b0, "R3 write during power-on pulse");
        end
        n_tests++;
        if (highs != PULSE_CYC - 1) begin
            n_fail++;
            $display("FAIL R1 power-on width: got %0d expected %0d", highs, PULSE_CYC - 1);
        end

        // R2: disabled watchdog ignores ticks and acknowledges
        for (int i = 0; i < 10; i++) step(1, i % 2, 0, 0, 0, 0);
        chk(wd_rst_o, 1'b0, "R2 disabled no pulse");

        // R4: code 3, fourth tick fires
        arm(3);
        chk(wd_en_o, 1'b1, "R4 enable set");
        ticks(3);
        chk(wd_rst_o, 1'b0, "R4 no pulse after three ticks");
        idle(1);
        step(1, 0, 0, 0, 0, 0);
        chk(wd_rst_o, 1'b1, "R4 pulse on fourth tick");
        chk(wd_en_o, 1'b0, "R8 enable cleared by fire");
        // R7: watchdog pulse width
        highs = 1;
        for (int i = 0; i < PULSE_CYC + 2; i++) begin
            idle(1);
            if (wd_rst_o) highs++;
        end
        n_tests++;
        if (highs != PULSE_CYC) begin
            n_fail++;
            $display("FAIL R7 watchdog width: got %0d expected %0d", highs, PULSE_CYC);
        end
        // R8: no further pulse without re-enable
        ticks(10);
        chk(wd_rst_o, 1'b0, "R8 no pulse after fire");

        // R5: valid acknowledge restarts the count
        arm(3);
        ticks(2);
        step(0, 1, 0, 0, 0, 0);
        ticks(3);
        chk(wd_rst_o, 1'b0, "R5 count restarted by ack");
        idle(1);
        step(1, 0, 0, 0, 0, 0);
        chk(wd_rst_o, 1'b1, "R5 pulse four ticks after ack");
        wait_pulse_end();

        // R6: early acknowledge fires at once
        arm(3);
        ticks(1);
        step(0, 1, 0, 0, 0, 0);
        chk(wd_rst_o, 1'b1, "R6 early ack fires");
        wait_pulse_end();

        // R10: valid ack on the expiring tick wins
        arm(2);
        ticks(2);
        idle(1);
        step(1, 1, 0, 0, 0, 0);
        chk(wd_rst_o, 1'b0, "R10 ack beats expiry");
        idle(1);
        ticks(2);
        chk(wd_rst_o, 1'b0, "R10 count from zero after tie");
        idle(1);
        step(1, 0, 0, 0, 0, 0);
        chk(wd_rst_o, 1'b1, "R10 full timeout after tie");
        wait_pulse_end();

        // R11: writing enable 0 disables
        arm(1);
        step(0, 0, 1, 0, 1, 0);
        chk(wd_en_o, 1'b0, "R11 enable cleared by write");
        for (int i = 0; i < 10; i++) step(1, i % 3 == 0, 0, 0, 0, 0);
        chk(wd_rst_o, 1'b0, "R11 disabled no pulse");

        // R9: hard clear aborts an active pulse
        arm(3);
        ticks(1);
        step(0, 1, 0, 0, 0, 0);
        chk(wd_rst_o, 1'b1, "R9 pulse before clear");
        step(0, 0, 0, 0, 0, 1);
        chk(wd_rst_o, 1'b0, "R9 clear drops pulse");
        step(0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 1);
        chk(wd_rst_o, 1'b0, "R9 held clear keeps output low");
        chk(wd_en_o, 1'b0, "R9 clear drops enable");
        idle(PULSE_CYC + 2);
        chk(wd_rst_o, 1'b0, "R9 release starts no pulse");
        // R9: clear on the expiring tick
        arm(1);
        ticks(1);
        idle(1);
        step(1, 0, 0, 0, 0, 1);
        chk(wd_rst_o, 1'b0, "R9 clear beats expiry");
        chk(wd_en_o, 1'b0, "R9 enable cleared with expiry");
        ticks(5);
        chk(wd_rst_o, 1'b0, "R9 quiet after clear");

        idle(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule